// File: doc/BRIEF.md
# Keyboard Serial Frame Receiver

This block takes the two open-collector lines of a PS/2 keyboard, clock and data, and turns each device-to-host frame into a byte delivered on the system clock. Both lines are first brought into the system clock domain. On every falling edge of the keyboard clock the block samples the data line. A small state machine then checks the frame and collects it: a low start bit, eight data bits arriving least significant bit first, an odd-parity bit and a high stop bit.

A frame that passes every check comes out as a single-cycle valid strobe together with the byte. If the parity bit is wrong, the byte is discarded and the block raises a one-cycle request asking a companion transmitter to send the resend command to the keyboard. Frames with a bad start or stop bit are dropped without any output. If the keyboard clock stays silent for a set number of microseconds, any partial frame is abandoned. While the companion transmitter reports that it is busy, the bus is ignored.

Top module: `kbd_frame_rx`

## Requirements
- R1: A well-formed frame produces `rx_valid` high for exactly one cycle, with `rx_byte` holding the eight data bits. The first data bit received is bit 0 and the last is bit 7.
- R2: A falling edge that samples data high while the receiver waits for a start bit is ignored. The next frame is received normally.
- R3: Parity is odd. The parity bit must be 1 when the data bits contain an even number of ones, and 0 otherwise. A matching parity bit lets the frame complete.
- R4: On a parity mismatch, no byte is delivered. `resend_req` is high for one cycle, `resend_cmd` reads 8'hFE, and the receiver returns to waiting for a start bit.
- R5: A frame whose stop bit is sampled low produces neither `rx_valid` nor `resend_req`. The next frame is received normally.
- R6: If no keyboard clock falling edge is seen for `TIMEOUT_US` microseconds (default 100), a partial frame is abandoned. A following complete frame is received correctly.
- R7: A pause between bits that is shorter than the timeout does not disturb the frame in progress.
- R8: Falling edges that occur while `tx_busy` is high have no effect. No output is produced for them, and the receiver state does not advance.
- R9: During and after reset, `rx_valid` and `resend_req` are low and `rx_byte` is 0.
- R10: `rx_valid` and `resend_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbd_clk | input | 1 | Keyboard clock line (asynchronous) |
| kbd_dat | input | 1 | Keyboard data line (asynchronous) |
| tx_busy | input | 1 | Companion transmitter owns the bus |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | 8 | Last byte received |
| resend_req | output | 1 | One-cycle request to send the resend command |
| resend_cmd | output | 8 | Command byte for the resend request (8'hFE) |

## Verification
The data patterns are chosen so that bit-order and parity mistakes show up. All zeros and all ones, single bits at either end, and mixed bytes with even and odd ones counts each expose a different error: a reversed shift, a stuck bit, or an inverted parity rule. Corrupted frames use a high start bit, a flipped parity bit and a low stop bit. Each is followed by a good frame, which shows that the receiver went back to a clean state. Timing patterns set a silence longer than the timeout against a pause shorter than it, so that an abort and a tolerated gap can be told apart. A whole frame sent while the transmitter is busy confirms that those edges are not seen.

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx #(
  parameter int          CLK_HZ     = 50_000_000,
  parameter int          TIMEOUT_US = 100,
  parameter logic [7:0]  RESEND_CODE = 8'hFE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kbd_clk,
  input  logic       kbd_dat,
  input  logic       tx_busy,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       resend_req,
  output logic [7:0] resend_cmd
);
  localparam int DIV   = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int DIV_W = $clog2(DIV + 1);
  localparam int US_W  = $clog2(TIMEOUT_US + 1);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_PAR, S_STOP} state_t;

  state_t           state;
  logic [2:0]       ck_s;
  logic [1:0]       dt_s;
  logic [7:0]       sh;
  logic [DIV_W-1:0] div_cnt;
  logic [US_W-1:0]  us_cnt;

  wire bit_in    = dt_s[1];
  wire take      = ck_s[2] & ~ck_s[1] & ~tx_busy;
  wire timed_out = (us_cnt == US_W'(TIMEOUT_US));

  assign resend_cmd = RESEND_CODE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_s <= '1;
      dt_s <= '1;
    end else begin
      ck_s <= {ck_s[1:0], kbd_clk};
      dt_s <= {dt_s[0], kbd_dat};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || take) begin
      div_cnt <= '0;
      us_cnt  <= '0;
    end else if (div_cnt == DIV_W'(DIV - 1)) begin
      div_cnt <= '0;
      if (!timed_out) us_cnt <= us_cnt + 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      sh         <= '0;
      rx_byte    <= '0;
      rx_valid   <= 1'b0;
      resend_req <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      resend_req <= 1'b0;
      if (take) begin
        case (state)
          S_IDLE: if (!bit_in) begin
            state <= S_DATA;
            sh    <= 8'h80;
          end
          S_DATA: begin
            sh <= {bit_in, sh[7:1]};
            if (sh[0]) state <= S_PAR;
          end
          S_PAR: if (bit_in == ~^sh) begin
            state <= S_STOP;
          end else begin
            state      <= S_IDLE;
            resend_req <= 1'b1;
          end
          default: begin
            state <= S_IDLE;
            if (bit_in) begin
              rx_valid <= 1'b1;
              rx_byte  <= sh;
            end
          end
        endcase
      end else if (timed_out) begin
        state <= S_IDLE;
      end
    end
  end
endmodule

module kbd_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_busy,
  input logic       rx_valid,
  input logic       resend_req,
  input logic [7:0] resend_cmd
);
  // R10
  exclusive_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && resend_req));

  // R1
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R4
  resend_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resend_req |=> !resend_req);

  // R4
  resend_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resend_req |-> resend_cmd == 8'hFE);

  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_busy) |-> !rx_valid && !resend_req);
endmodule

bind kbd_frame_rx kbd_frame_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .rx_valid(rx_valid),
  .resend_req(resend_req), .resend_cmd(resend_cmd)
);

// File: tb/tb_kbd_frame_rx.sv
module tb_kbd_frame_rx;
  localparam int HALF_NS = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kbd_clk = 1'b1;
  logic       kbd_dat = 1'b1;
  logic       tx_busy = 1'b0;
  logic       rx_valid, resend_req;
  logic [7:0] rx_byte, resend_cmd;

  int checks = 0;
  int failures = 0;

  typedef struct { bit resend; logic [7:0] val; string tag; } exp_t;
  exp_t expq[$];

  kbd_frame_rx dut (
    .clk(clk), .rst_n(rst_n), .kbd_clk(kbd_clk), .kbd_dat(kbd_dat),
    .tx_busy(tx_busy), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .resend_req(resend_req), .resend_cmd(resend_cmd)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic kbit(input logic b);
    kbd_dat = b;
    #(HALF_NS);
    kbd_clk = 1'b0;
    #(HALF_NS);
    kbd_clk = 1'b1;
  endtask

  task automatic frame(input logic [7:0] b, input bit bad_par, input bit bad_stop,
                       input int gap_after, input int gap_ns);
    kbit(1'b0);
    for (int i = 0; i < 8; i++) begin
      kbit(b[i]);
      if (i == gap_after) #(gap_ns);
    end
    kbit((~^b) ^ bad_par);
    kbit(!bad_stop);
    kbd_dat = 1'b1;
    #(4 * HALF_NS);
  endtask

  task automatic push(input bit rs, input logic [7:0] v, input string tag);
    exp_t e;
    e.resend = rs; e.val = v; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic good(input logic [7:0] b, input string tag);
    push(1'b0, b, tag);
    frame(b, 1'b0, 1'b0, -1, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && (rx_valid || resend_req)) begin
      chk(!(rx_valid && resend_req), "R10", "both strobes", {rx_valid, resend_req}, 2);
      if (expq.size() == 0) begin
        chk(1'b0, "R5", "unexpected output", rx_byte, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (e.resend) begin
          chk(resend_req, e.tag, "resend_req", resend_req, 1);
          chk(resend_cmd == 8'hFE, e.tag, "resend_cmd", resend_cmd, 8'hFE);
        end else begin
          chk(rx_valid && rx_byte == e.val, e.tag, "rx_byte", rx_byte, e.val);
        end
      end
    end
  end

  initial begin
    #3_500_000;
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!rx_valid && !resend_req, "R9", "strobes in reset", {rx_valid, resend_req}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rx_byte == 8'h00, "R9", "rx_byte after reset", rx_byte, 0);
    chk(!rx_valid && !resend_req, "R9", "strobes after reset", {rx_valid, resend_req}, 0);

    // R1 R3: varied data patterns
    good(8'h00, "R3");
    good(8'hFF, "R3");
    good(8'h01, "R1");
    good(8'h80, "R1");
    good(8'h1C, "R1");
    good(8'hA7, "R3");

    // R2: lone edge with data high, then a good frame
    kbit(1'b1);
    #(2 * HALF_NS);
    good(8'h77, "R2");

    // R4: parity error then recovery
    push(1'b1, 8'hFE, "R4");
    frame(8'h5A, 1'b1, 1'b0, -1, 0);
    good(8'h5A, "R4");

    // R5: stop low dropped
    frame(8'h33, 1'b0, 1'b1, -1, 0);
    good(8'h34, "R5");

    // R6: partial frame abandoned after silence
    kbit(1'b0);
    for (int i = 0; i < 4; i++) kbit(1'b0);
    #150_000;
    good(8'h3C, "R6");

    // R7: 80 us pause mid-frame
    push(1'b0, 8'hC9, "R7");
    frame(8'hC9, 1'b0, 1'b0, 3, 80_000);

    // R8: frame during busy has no effect
    tx_busy = 1'b1;
    frame(8'h42, 1'b0, 1'b0, -1, 0);
    tx_busy = 1'b0;
    #(2 * HALF_NS);
    good(8'h99, "R8");

    #30_000;
    chk(expq.size() == 0, "R1", "missing outputs", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule